// File: doc/BRIEF.md
# Seek Completion Interrupt Status Unit

This block tracks why a floppy-style disk controller has raised its interrupt and answers a sense-interrupt query with the cause. Each of up to four drives has a slot that holds a pending cause (normal seek end, abnormal seek end or polling event), the present cylinder number reported when its last seek ended, and a busy flag. A seek-type command has no result phase. The busy flag is set when the command starts and clears only when a sense query retires that drive's seek.

A sense query is a one-cycle pulse on `sense_i`. One cycle later `rsp_valid_o` pulses, and `rsp_st0_o` and `rsp_pcn_o` carry status byte 0 and the present cylinder. The query retires the pending cause of the lowest-numbered drive that has one. Each query also clears a pending result-phase flag. The interrupt output is high while any drive has a pending cause, while the result-phase flag is set, or while the non-DMA transfer request level is high.

Top module: `seek_irq_status`

## Requirements
- R1: After reset, `irq_o`, `busy_o` and `rsp_valid_o` are 0, and every stored cylinder is 0.
- R2: A `cmd_start_i` pulse sets `busy_o[cmd_drive_i]`. The bit stays set through the end of the seek and clears in the cycle after the sense query that retires that drive's seek. A busy bit never clears in any other way.
- R3: A normal seek end (`ev_done_i`=1, `ev_abn_i`=0) is reported with status byte 0 equal to {IC=00 in bits 7:6, SE=1 in bit 5, bits 4:2 = 0, drive number in bits 1:0}. Bit 2 is the head address and always reads 0.
- R4: An abnormal seek end (`ev_done_i`=1, `ev_abn_i`=1) is reported with IC=01 and SE=1. The other bits follow R3.
- R5: A polling event (`ev_poll_i`) is reported with IC=11 and SE=0, with the drive number in bits 1:0. The returned cylinder is the drive's stored value, which the poll does not change.
- R6: The cylinder returned for a seek end is the `ev_cyl_i` value presented with that seek end.
- R7: `rsp_valid_o` is a one-cycle pulse, high exactly in the cycle after each `sense_i` pulse. The response fields are valid in that cycle.
- R8: When several drives have pending causes, successive sense queries report them one at a time, in ascending drive number order.
- R9: `irq_o` is high while any drive has a pending cause, a result-phase flag (`result_i` pulse) is set, or `xfer_req_i` is high. Retiring the last cause drops it in the next cycle.
- R10: A sense query with no drive pending returns status byte 0x80 (IC=10, all other bits 0) and cylinder 0. It retires nothing.
- R11: A seek end on a drive replaces a pending polling cause on the same drive. A polling event does not replace a pending seek cause.
- R12: Every sense query clears the result-phase flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start_i | input | 1 | Pulse: a seek-type command starts on `cmd_drive_i` |
| cmd_drive_i | input | 2 | Drive of the starting command |
| ev_done_i | input | 1 | Pulse: a seek or recalibrate on `ev_drive_i` has ended |
| ev_abn_i | input | 1 | With `ev_done_i`: the end was abnormal |
| ev_poll_i | input | 1 | Pulse: a polling event on `ev_drive_i` |
| ev_drive_i | input | 2 | Drive of the event |
| ev_cyl_i | input | 8 | Present cylinder at the seek end |
| result_i | input | 1 | Pulse: the controller entered a result phase |
| xfer_req_i | input | 1 | Level: a non-DMA execution-phase transfer is needed |
| sense_i | input | 1 | Pulse: sense-interrupt query |
| rsp_valid_o | output | 1 | Response valid, one cycle |
| rsp_st0_o | output | 8 | Status byte 0 of the response |
| rsp_pcn_o | output | 8 | Present cylinder of the response |
| irq_o | output | 1 | Interrupt request |
| busy_o | output | 4 | Per-drive busy flags |

## Verification
On every cycle, the assertions check the following:
- the one-cycle spacing of query and response;
- that status byte 0 encodes one of the four legal cause codes, with the head bit clear;
- that an invalid response carries cylinder 0;
- that a busy bit falls only after a query;
- that the transfer request always raises the interrupt.

Only the bench scenarios can show that a response names the right drive and cylinder. The same holds for ascending-order draining, seek-over-poll replacement, and the interrupt dropping exactly when the last cause is retired.

// File: rtl/seek_irq_pkg.sv
package seek_irq_pkg;

    typedef enum logic [1:0] {
        PEND_NONE = 2'd0,
        PEND_POLL = 2'd1,
        PEND_OK   = 2'd2,
        PEND_ABN  = 2'd3
    } pend_e;

    localparam logic [7:0] ST0_INVALID = 8'h80;

    // Build status byte 0: IC in 7:6, SE in 5, head/other bits 0, drive in 1:0
    function automatic logic [7:0] make_st0(input pend_e code, input logic [1:0] ds);
        logic [7:0] b;
        b = 8'h00;
        case (code)
            PEND_OK:   b[7:5] = 3'b001;
            PEND_ABN:  b[7:5] = 3'b011;
            PEND_POLL: b[7:5] = 3'b110;
            default:   b[7:5] = 3'b100;
        endcase
        b[1:0] = ds;
        return b;
    endfunction

endpackage

// File: rtl/seek_irq_slot.sv
module seek_irq_slot
    import seek_irq_pkg::*;
#(
    parameter int CYL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             done_i,
    input  logic             abn_i,
    input  logic             poll_i,
    input  logic [CYL_W-1:0] cyl_i,
    input  logic             retire_i,
    output pend_e            code_o,
    output logic [CYL_W-1:0] cyl_o,
    output logic             busy_o
);

    typedef struct packed {
        pend_e            code;
        logic [CYL_W-1:0] cyl;
        logic             busy;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (retire_i) begin
            if (st_q.code == PEND_OK || st_q.code == PEND_ABN) st_d.busy = 1'b0;
            st_d.code = PEND_NONE;
        end
        if (start_i) st_d.busy = 1'b1;
        if (done_i) begin
            st_d.code = abn_i ? PEND_ABN : PEND_OK;
            st_d.cyl  = cyl_i;
        end else if (poll_i && st_d.code == PEND_NONE) begin
            st_d.code = PEND_POLL;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{code: PEND_NONE, cyl: '0, busy: 1'b0};
        else        st_q <= st_d;
    end

    assign code_o = st_q.code;
    assign cyl_o  = st_q.cyl;
    assign busy_o = st_q.busy;

endmodule

// File: rtl/seek_irq_pick.sv
module seek_irq_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     req_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);

    // Lowest index wins: scan downward so the last hit is the lowest
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/seek_irq_status.sv
module seek_irq_status
    import seek_irq_pkg::*;
#(
    parameter int N_DRV = 4,
    parameter int CYL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_start_i,
    input  logic [1:0]       cmd_drive_i,
    input  logic             ev_done_i,
    input  logic             ev_abn_i,
    input  logic             ev_poll_i,
    input  logic [1:0]       ev_drive_i,
    input  logic [CYL_W-1:0] ev_cyl_i,
    input  logic             result_i,
    input  logic             xfer_req_i,
    input  logic             sense_i,
    output logic             rsp_valid_o,
    output logic [7:0]       rsp_st0_o,
    output logic [CYL_W-1:0] rsp_pcn_o,
    output logic             irq_o,
    output logic [N_DRV-1:0] busy_o
);

    localparam int IDX_W = 2;

    typedef struct packed {
        logic             rsp_valid;
        logic [7:0]       st0;
        logic [CYL_W-1:0] pcn;
        logic             result;
    } top_t;

    top_t r_d, r_q;

    pend_e            code_w [N_DRV];
    logic [CYL_W-1:0] cyl_w  [N_DRV];
    logic [N_DRV-1:0] pend_w;
    logic [N_DRV-1:0] retire_w;
    logic             found_w;
    logic [IDX_W-1:0] idx_w;

    for (genvar g = 0; g < N_DRV; g++) begin : g_slot
        seek_irq_slot #(.CYL_W(CYL_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .start_i  (cmd_start_i && cmd_drive_i == IDX_W'(g)),
            .done_i   (ev_done_i && ev_drive_i == IDX_W'(g)),
            .abn_i    (ev_abn_i),
            .poll_i   (ev_poll_i && ev_drive_i == IDX_W'(g)),
            .cyl_i    (ev_cyl_i),
            .retire_i (retire_w[g]),
            .code_o   (code_w[g]),
            .cyl_o    (cyl_w[g]),
            .busy_o   (busy_o[g])
        );
        assign pend_w[g] = (code_w[g] != PEND_NONE);
    end

    seek_irq_pick #(.N(N_DRV), .IDX_W(IDX_W)) u_pick (
        .req_i   (pend_w),
        .found_o (found_w),
        .idx_o   (idx_w)
    );

    always_comb begin
        r_d           = r_q;
        r_d.rsp_valid = 1'b0;
        retire_w      = '0;
        if (sense_i) begin
            r_d.rsp_valid = 1'b1;
            r_d.result    = 1'b0;
            if (found_w) begin
                retire_w[idx_w] = 1'b1;
                r_d.st0         = make_st0(code_w[idx_w], idx_w);
                r_d.pcn         = cyl_w[idx_w];
            end else begin
                r_d.st0 = ST0_INVALID;
                r_d.pcn = '0;
            end
        end
        if (result_i) r_d.result = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{rsp_valid: 1'b0, st0: '0, pcn: '0, result: 1'b0};
        else        r_q <= r_d;
    end

    assign rsp_valid_o = r_q.rsp_valid;
    assign rsp_st0_o   = r_q.st0;
    assign rsp_pcn_o   = r_q.pcn;
    assign irq_o       = (|pend_w) | r_q.result | xfer_req_i;

endmodule

// File: rtl/seek_irq_status_chk.sv
module seek_irq_status_chk #(
    parameter int N_DRV = 4,
    parameter int CYL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sense_i,
    input logic             xfer_req_i,
    input logic             rsp_valid_o,
    input logic [7:0]       rsp_st0_o,
    input logic [CYL_W-1:0] rsp_pcn_o,
    input logic             irq_o,
    input logic [N_DRV-1:0] busy_o
);

    // R7
    rsp_follows_sense_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sense_i |=> rsp_valid_o);

    // R7
    rsp_only_after_sense_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sense_i |=> !rsp_valid_o);

    // R3
    head_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> rsp_st0_o[4:2] == 3'b000);

    // R4
    seek_cause_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && rsp_st0_o[5]) |-> rsp_st0_o[7] == 1'b0);

    // R5
    poll_cause_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && !rsp_st0_o[5]) |-> rsp_st0_o[7] == 1'b1);

    // R10
    invalid_rsp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && rsp_st0_o[7:6] == 2'b10) |-> (rsp_pcn_o == '0 && rsp_st0_o[5:0] == 6'd0));

    // R2
    busy_drop_after_sense_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(busy_o) & ~busy_o)) |-> $past(sense_i));

    // R9
    xfer_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req_i |-> irq_o);

endmodule

bind seek_irq_status seek_irq_status_chk #(.N_DRV(N_DRV), .CYL_W(CYL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sense_i     (sense_i),
    .xfer_req_i  (xfer_req_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_st0_o   (rsp_st0_o),
    .rsp_pcn_o   (rsp_pcn_o),
    .irq_o       (irq_o),
    .busy_o      (busy_o)
);

// File: tb/seek_irq_status_test.sv
module seek_irq_status_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_start_i = 0, ev_done_i = 0, ev_abn_i = 0, ev_poll_i = 0;
    logic [1:0] cmd_drive_i = 0, ev_drive_i = 0;
    logic [7:0] ev_cyl_i = 0;
    logic       result_i = 0, xfer_req_i = 0, sense_i = 0;
    logic       rsp_valid_o, irq_o;
    logic [7:0] rsp_st0_o, rsp_pcn_o;
    logic [3:0] busy_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] stored [4];

    always #2 clk = ~clk;

    seek_irq_status uut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic start_cmd(input int d);
        cmd_start_i = 1; cmd_drive_i = 2'(d);
        tick();
        cmd_start_i = 0;
    endtask

    task automatic seek_end(input int d, input logic abn, input logic [7:0] cyl);
        ev_done_i = 1; ev_abn_i = abn; ev_drive_i = 2'(d); ev_cyl_i = cyl;
        tick();
        ev_done_i = 0; ev_abn_i = 0;
        stored[d] = cyl;
    endtask

    task automatic poll_ev(input int d);
        ev_poll_i = 1; ev_drive_i = 2'(d);
        tick();
        ev_poll_i = 0;
    endtask

    task automatic sense(input string req, input logic [7:0] st0, input logic [7:0] pcn);
        sense_i = 1;
        tick();
        sense_i = 0;
        check({req, " R7 valid"}, 32'(rsp_valid_o), 1);
        check({req, " st0"}, 32'(rsp_st0_o), 32'(st0));
        check({req, " pcn"}, 32'(rsp_pcn_o), 32'(pcn));
        tick();
        check("R7 pulse", 32'(rsp_valid_o), 0);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) stored[i] = 8'd0;
        @(negedge clk); tick();
        rst_n = 1;
        tick();
        // R1 reset state
        check("R1 irq", 32'(irq_o), 0);
        check("R1 busy", 32'(busy_o), 0);
        check("R1 valid", 32'(rsp_valid_o), 0);

        // R2 R3 R4 R6 sweep over drives and end kinds
        for (int d = 0; d < 4; d++) begin
            for (int a = 0; a < 2; a++) begin
                logic [7:0] cyl;
                cyl = 8'(d * 37 + a * 5 + 3);
                start_cmd(d);
                check("R2 busy set", 32'(busy_o), 32'(1 << d));
                check("R9 irq idle", 32'(irq_o), 0);
                seek_end(d, a[0], cyl);
                check("R2 busy held", 32'(busy_o), 32'(1 << d));
                check("R9 irq set", 32'(irq_o), 1);
                sense(a ? "R4" : "R3", 8'((a ? 8'h60 : 8'h20) | d), cyl);
                check("R2 busy clear", 32'(busy_o), 0);
                check("R9 irq clear", 32'(irq_o), 0);
            end
        end

        // R5 polling per drive, stored cylinder returned
        for (int d = 0; d < 4; d++) begin
            poll_ev(d);
            check("R5 irq", 32'(irq_o), 1);
            sense("R5", 8'(8'hC0 | d), stored[d]);
            check("R5 irq clear", 32'(irq_o), 0);
        end

        // R8 ascending order drain
        start_cmd(3); start_cmd(1); start_cmd(2);
        seek_end(3, 0, 8'd90); seek_end(1, 1, 8'd11); seek_end(2, 0, 8'd42);
        sense("R8 first", 8'h61, 8'd11);
        check("R8 busy", 32'(busy_o), 32'b1100);
        sense("R8 second", 8'h22, 8'd42);
        sense("R8 third", 8'h23, 8'd90);
        check("R9 drained", 32'(irq_o), 0);

        // R10 nothing pending
        sense("R10", 8'h80, 8'd0);
        check("R10 busy", 32'(busy_o), 0);

        // R12 result flag cleared by a query
        result_i = 1; tick(); result_i = 0;
        check("R9 result irq", 32'(irq_o), 1);
        sense("R12", 8'h80, 8'd0);
        check("R12 irq cleared", 32'(irq_o), 0);

        // R9 transfer request level
        xfer_req_i = 1; tick();
        check("R9 xfer high", 32'(irq_o), 1);
        xfer_req_i = 0; tick();
        check("R9 xfer low", 32'(irq_o), 0);

        // R11 seek replaces poll, poll does not replace seek
        start_cmd(2);
        poll_ev(2);
        seek_end(2, 0, 8'd77);
        poll_ev(2);
        sense("R11", 8'h22, 8'd77);
        sense("R11 single", 8'h80, 8'd0);
        check("R11 busy", 32'(busy_o), 0);

        // R2 poll retire leaves busy of an in-flight seek
        start_cmd(0);
        poll_ev(0);
        sense("R2 poll", 8'hC0, stored[0]);
        check("R2 busy kept", 32'(busy_o), 1);
        seek_end(0, 0, 8'd5);
        sense("R2 seek", 8'h20, 8'd5);
        check("R2 busy done", 32'(busy_o), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule